// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It tracks the sixteen-state test controller from the mode input, sampled on each rising edge of the test clock. It holds a three-bit instruction and decodes it to pick the data path placed between the serial input and the serial output. The data path is one of three: a single-bit pass-through stage, a 32-bit identification register, or a boundary chain that lives outside this block. For the boundary chain, the block supplies select, capture, shift and update strobes, and it takes back the chain's serial output.

Two mode flags go to the pad ring. One tells the pads to take their drive values from the boundary chain. The other forces every pad driver off. The port works only when a select pin is high and a test pin is low. Under any other pattern on those two pins, or while the active-low test reset is low, the controller is held in its reset state and the serial output stays undriven.

Top module: `tap_port`

## Requirements
- R1: The instruction register is 3 bits wide. In the Capture-IR state it loads 3'b001, so the first three bits shifted out of an instruction scan are 1, 0, 0, least significant bit first.
- R2: A reset, or a pass through Test-Logic-Reset, sets the instruction to the identification opcode 3'b010.
- R3: Opcode decode: 3'b111 selects bypass. 3'b000 and 3'b011 select boundary drive. 3'b001 selects boundary sample. 3'b100 and 3'b110 select float-all. 3'b010 selects identification.
- R4: Bypass and float-all both route the 1-bit pass-through stage. It captures 0, so a data scan returns 0 followed by the input delayed by one bit.
- R5: Boundary drive and boundary sample route `bnd_so` to `tdo`. `bnd_sel` is then high. `bnd_capture`, `bnd_shift` and `bnd_update` are high only in Capture-DR, Shift-DR and Update-DR while the boundary path is selected.
- R6: The identification instruction captures 32'h05B2203F. It is shifted out least significant bit first.
- R7: `trst_n` low resets the controller, the instruction and the serial output at once, without waiting for a clock edge.
- R8: The port is enabled only when `port_sel` is 1 and `port_test` is 0. Under any other pattern, `tdo_oe` is 0 and the controller stays in reset.
- R9: The test clock may be held high or low for any length of time without losing state.
- R10: `pads_float` is 1 exactly while a float-all opcode is held. `pads_from_chain` is 1 exactly while a boundary-drive opcode is held. Both are 0 after reset.
- R11: Five rising clock edges with `tms` high reach Test-Logic-Reset from any state.
- R12: `tms` and `tdi` are sampled on the rising edge. `tdo` changes only on the falling edge. `tdo_oe` is 1 only during Shift-IR and Shift-DR.
- R13: The unassigned opcode 3'b101 decodes as bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low asynchronous test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| port_sel | input | 1 | Compliance select pin, must be 1 to enable |
| port_test | input | 1 | Compliance test pin, must be 0 to enable |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| bnd_sel | output | 1 | Boundary chain is the selected data path |
| bnd_capture | output | 1 | Boundary chain capture strobe |
| bnd_shift | output | 1 | Boundary chain shift strobe |
| bnd_update | output | 1 | Boundary chain update strobe |
| pads_from_chain | output | 1 | Pads driven from the boundary update stage |
| pads_float | output | 1 | Force every pad output enable off |

## Verification
A wrong controller state appears at the ports within one falling edge: `tdo_oe` opens or closes at the wrong time, or a boundary strobe pulses outside its state. A wrong instruction appears at once on the two pad flags. On the next data scan it also appears as the wrong bit stream: an identification value, a one-bit-delayed echo, or the boundary pattern. The bench predicts each of these streams from the opcode alone. A bad capture or shift in any register shows up in the first bits of the next scan of that register.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS, PATH_BOUNDARY, PATH_DEVID
  } dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     float_all;
    logic     drive_chain;
  } op_decode_t;

  localparam logic [IR_W-1:0] OP_DEVID       = 3'b010;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  function automatic op_decode_t decode_op(input logic [IR_W-1:0] op);
    op_decode_t d;
    d.path        = PATH_BYPASS;
    d.float_all   = 1'b0;
    d.drive_chain = 1'b0;
    unique case (op)
      3'b000, 3'b011: begin d.path = PATH_BOUNDARY; d.drive_chain = 1'b1; end
      3'b001:         d.path = PATH_BOUNDARY;
      3'b010:         d.path = PATH_DEVID;
      3'b100, 3'b110: d.float_all = 1'b1;
      default:        d.path = PATH_BYPASS;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tap_rst_sync.sv
module tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

  // Checker: count consecutive rising edges with tms high
  logic [2:0] ones_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ones_cnt <= '0;
    else if (!tms)                ones_cnt <= '0;
    else if (ones_cnt != 3'd7)    ones_cnt <= ones_cnt + 3'd1;
  end

  p_five_ones_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_cnt >= 3'd5) |-> (state == ST_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_so
);
  logic [IR_W-1:0] sr_q, sr_d;
  logic [IR_W-1:0] ir_d;
  logic            sr_en, ir_en;

  always_comb begin
    sr_en = (state == ST_CAP_IR) || (state == ST_SH_IR);
    sr_d  = (state == ST_CAP_IR) ? IR_CAPTURE_PAT : {tdi, sr_q[IR_W-1:1]};
    ir_en = (state == ST_RESET) || (state == ST_UPD_IR);
    ir_d  = (state == ST_RESET) ? OP_DEVID : sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= IR_CAPTURE_PAT;
      ir   <= OP_DEVID;
    end else begin
      if (sr_en) sr_q <= sr_d;
      if (ir_en) ir   <= ir_d;
    end
  end

  assign ir_so = sr_q[0];

  p_capture_pattern_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (sr_q == 3'b001));
  p_reset_loads_devid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir == 3'b010));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h05B2203F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tap_state_e state,
  input  dr_path_e   path,
  input  logic       tdi,
  input  logic       bnd_so,
  output logic       dr_so
);
  logic            byp_q, byp_d, byp_en;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;
  logic            cap, sh;

  always_comb begin
    cap    = (state == ST_CAP_DR);
    sh     = (state == ST_SH_DR);
    byp_en = (path == PATH_BYPASS) && (cap || sh);
    byp_d  = cap ? 1'b0 : tdi;
    id_en  = (path == PATH_DEVID) && (cap || sh);
    id_d   = cap ? ID_VALUE : {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else begin
      if (byp_en) byp_q <= byp_d;
      if (id_en)  id_q  <= id_d;
    end
  end

  always_comb begin
    unique case (path)
      PATH_BOUNDARY: dr_so = bnd_so;
      PATH_DEVID:    dr_so = id_q[0];
      default:       dr_so = byp_q;
    endcase
  end

  p_id_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && path == PATH_DEVID) |=> (id_q == ID_VALUE));
  p_bypass_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && path == PATH_BYPASS) |=> (byp_q == 1'b0));
endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int              ID_W       = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h05B2203F,
  parameter int              SYNC_STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic port_sel,
  input  logic port_test,
  input  logic bnd_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bnd_sel,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update,
  output logic pads_from_chain,
  output logic pads_float
);
  logic            arst_n, rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so, dr_so;
  op_decode_t      dec;
  logic            in_shift, tdo_d;

  assign arst_n = trst_n & port_sel & ~port_test;

  tap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(tck), .arst_n(arst_n), .rst_n(rst_n));

  tap_fsm u_fsm (.clk(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir u_ir (.clk(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
               .ir(ir), .ir_so(ir_so));

  always_comb dec = decode_op(ir);

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .clk(tck), .rst_n(rst_n), .state(state), .path(dec.path),
    .tdi(tdi), .bnd_so(bnd_so), .dr_so(dr_so));

  always_comb begin
    bnd_sel         = (dec.path == PATH_BOUNDARY);
    bnd_capture     = bnd_sel && (state == ST_CAP_DR);
    bnd_shift       = bnd_sel && (state == ST_SH_DR);
    bnd_update      = bnd_sel && (state == ST_UPD_DR);
    pads_from_chain = dec.drive_chain;
    pads_float      = dec.float_all;
    in_shift        = (state == ST_SH_IR) || (state == ST_SH_DR);
    tdo_d           = (state == ST_SH_IR) ? ir_so : dr_so;
  end

  // Output stage on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift;
      if (in_shift) tdo <= tdo_d;
    end
  end

  p_oe_only_in_shift_r12: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
  p_update_exits_r5: assert property (@(posedge tck) disable iff (!rst_n)
    bnd_update |=> (state == ST_SEL_DR || state == ST_IDLE));
  p_oe_off_when_disabled_r8: assert property (@(posedge tck)
    !arst_n |-> !tdo_oe);

  always_comb begin
    p_flags_exclusive_r10: assert (!(pads_float && pads_from_chain));
  end
endmodule

// File: tb/tap_port_test.sv
module tap_port_test;
  localparam int HALF = 10; // 50 MHz test clock

  logic tck, trst_n, tms, tdi, port_sel, port_test, bnd_so;
  logic tdo, tdo_oe, bnd_sel, bnd_capture, bnd_shift, bnd_update;
  logic pads_from_chain, pads_float;

  int n_checks, n_fail, n_updates, rise_glitch;
  bit done;
  logic [7:0] chain;

  tap_port uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .port_sel(port_sel), .port_test(port_test), .bnd_so(bnd_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bnd_sel(bnd_sel),
    .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update),
    .pads_from_chain(pads_from_chain), .pads_float(pads_float));

  // Bench model of an external 8-bit boundary chain
  always @(posedge tck) begin
    if (bnd_capture)    chain <= 8'hA5;
    else if (bnd_shift) chain <= {tdi, chain[7:1]};
    if (bnd_update)     n_updates++;
  end
  assign bnd_so = chain[0];

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected path: 0 bypass, 1 boundary, 2 identification
  function automatic int exp_path(input logic [2:0] op);
    case (op)
      3'b000, 3'b011, 3'b001: return 1;
      3'b010:                 return 2;
      default:                return 0;
    endcase
  endfunction
  function automatic bit exp_float(input logic [2:0] op);
    return (op == 3'b100) || (op == 3'b110);
  endfunction
  function automatic bit exp_drive(input logic [2:0] op);
    return (op == 3'b000) || (op == 3'b011);
  endfunction
  function automatic logic [31:0] exp_scan(input logic [2:0] op, input logic [31:0] din);
    case (exp_path(op))
      1:       return {din[23:0], 8'hA5};
      2:       return 32'h05B2203F;
      default: return {din[30:0], 1'b0};
    endcase
  endfunction

  int stall; // when nonzero, clock held high this long on the next step

  task automatic step(input logic m, input logic d);
    logic pre;
    tms = m; tdi = d;
    #(HALF);
    pre = tdo;
    tck = 1'b1;
    #1;
    if (tdo !== pre) rise_glitch++;
    #(HALF - 1 + stall);
    stall = 0;
    tck = 1'b0;
    #1;
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap, output bit oe_ok);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    oe_ok = 1;
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      if (tdo_oe !== 1'b1) oe_ok = 0;
      step(i == 2, op[i]);
    end
    if (tdo_oe !== 1'b0) oe_ok = 0;
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [31:0] din, output logic [31:0] dout, input int hold_at);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 32; i++) begin
      dout[i] = tdo;
      if (i == hold_at) begin
        stall = 700;
        #900; // clock also parked low for a long time
      end
      step(i == 31, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic go_reset_idle();
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
  endtask

  initial begin
    logic [2:0]  cap;
    logic [31:0] din, dout;
    bit          oe_ok;
    logic [2:0]  op;
    int          upd0;

    void'($urandom(32'h5EED_1234));
    n_checks = 0; n_fail = 0; n_updates = 0; rise_glitch = 0; stall = 0;
    tck = 0; tms = 1; tdi = 0; trst_n = 0; port_sel = 1; port_test = 0;
    chain = 8'h00;
    step(1, 0); step(1, 0);
    check(tdo_oe === 1'b0, "R7 oe in reset", {31'b0, tdo_oe}, 0);
    check(pads_float === 0 && pads_from_chain === 0, "R10 flags at reset",
          {30'b0, pads_float, pads_from_chain}, 0);
    trst_n = 1;
    go_reset_idle();

    // R2/R6: after reset the identification register is selected
    din = $urandom();
    scan_dr(din, dout, -1);
    check(dout === 32'h05B2203F, "R2 R6 idcode after reset", dout, 32'h05B2203F);

    // Directed walk over every opcode, then random ones
    for (int k = 0; k < 28; k++) begin
      op = (k < 8) ? k[2:0] : 3'($urandom());
      scan_ir(op, cap, oe_ok);
      check(cap === 3'b001, "R1 capture pattern", {29'b0, cap}, 32'h1);
      check(oe_ok, "R12 oe window in shift-ir", {31'b0, oe_ok}, 1);
      check(pads_float === exp_float(op), "R10 float flag",
            {31'b0, pads_float}, {31'b0, exp_float(op)});
      check(pads_from_chain === exp_drive(op), "R10 drive flag",
            {31'b0, pads_from_chain}, {31'b0, exp_drive(op)});
      check(bnd_sel === (exp_path(op) == 1), "R5 boundary select",
            {31'b0, bnd_sel}, {31'b0, exp_path(op) == 1});
      upd0 = n_updates;
      din = $urandom();
      scan_dr(din, dout, (k == 5) ? 13 : -1);
      if (op == 3'b101)
        check(dout === exp_scan(op, din), "R13 code 101 bypass", dout, exp_scan(op, din));
      else if (exp_path(op) == 0)
        check(dout === exp_scan(op, din), "R4 bypass path", dout, exp_scan(op, din));
      else if (exp_path(op) == 1)
        check(dout === exp_scan(op, din), "R5 boundary path", dout, exp_scan(op, din));
      else
        check(dout === exp_scan(op, din), "R3 R6 idcode path", dout, exp_scan(op, din));
      if (k == 5)
        check(dout === exp_scan(op, din), "R9 clock stopped", dout, exp_scan(op, din));
      check((n_updates - upd0) == ((exp_path(op) == 1) ? 1 : 0), "R5 update strobe",
            n_updates - upd0, (exp_path(op) == 1) ? 1 : 0);
    end

    // R11: from the middle of a data shift, five tms-high edges reset
    scan_ir(3'b100, cap, oe_ok);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    check(tdo_oe === 1'b1, "R12 oe in shift-dr", {31'b0, tdo_oe}, 1);
    go_reset_idle();
    check(pads_float === 1'b0, "R11 reset clears float", {31'b0, pads_float}, 0);
    scan_dr(32'h0, dout, -1);
    check(dout === 32'h05B2203F, "R11 idcode after tms reset", dout, 32'h05B2203F);

    // R7: asynchronous reset clears the instruction immediately
    scan_ir(3'b011, cap, oe_ok);
    check(pads_from_chain === 1'b1, "R3 code 011 drives", {31'b0, pads_from_chain}, 1);
    #3 trst_n = 0; #2;
    check(pads_from_chain === 1'b0, "R7 async reset", {31'b0, pads_from_chain}, 0);
    trst_n = 1;
    go_reset_idle();

    // R8: compliance pattern gates the port
    scan_ir(3'b111, cap, oe_ok);
    step(1, 0); step(0, 0); step(0, 0);
    check(tdo_oe === 1'b1, "R8 oe enabled", {31'b0, tdo_oe}, 1);
    port_sel = 0; #2;
    check(tdo_oe === 1'b0, "R8 select low disables", {31'b0, tdo_oe}, 0);
    port_sel = 1; port_test = 1;
    step(0, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    check(tdo_oe === 1'b0, "R8 test high disables", {31'b0, tdo_oe}, 0);
    port_test = 0;
    go_reset_idle();
    scan_dr(32'h0, dout, -1);
    check(dout === 32'h05B2203F, "R8 restart at idcode", dout, 32'h05B2203F);

    check(rise_glitch == 0, "R12 tdo stable at rising edge", rise_glitch, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule